// File: doc/BRIEF.md
# Timer Compare Match Unit

This block holds a compare value and tests it against the count of a free-running timer on every clock. When the two become equal, the unit takes the action that a 4-bit mode field selects. It can drive its output latch high or low. It can raise only its interrupt flag. It can also fire a trigger event, which resets the timer and can start an external converter. The timer, the interrupt controller and the converter are outside the block. It sees only the timer count, and it drives back a timer-clear pulse and a converter-start pulse.

The trigger mode clears the timer through a pulse of its own. That pulse never touches the timer's overflow path, so the compare value acts as a programmable period for the timer. The interrupt flag is raised on every match in every active mode and stays raised until a clear input pulses. The output pin drives the latch only when the external direction input selects output.

Top module: `cmp_match_unit`

## Requirements
- R1: While reset is asserted and after it is released, pin latch, interrupt flag, timer-clear pulse and converter-start pulse are all 0.
- R2: In mode 4'b1000, a match sets the latch to 1 at the clock edge that ends the cycle in which the timer count equals the compare value.
- R3: In mode 4'b1001, a match clears the latch to 0 at that same edge.
- R4: In mode 4'b1010, a match leaves the latch unchanged and only raises the interrupt flag.
- R5: Any match in the four active modes (4'b10xx) sets the interrupt flag at that edge. The flag then stays 1 until flag_clr_i is sampled high. A set and a clear in the same cycle leave the flag at 1.
- R6: In mode 4'b1011, a match leaves the latch unchanged and makes timer_clr_o high for exactly one cycle. In that same cycle, conv_start_o is high only if conv_en_i was high during the match cycle.
- R7: A timer count that stays equal to the compare value for several cycles yields a single match event.
- R8: Mode 4'b0000 forces the latch to 0 at the next clock edge.
- R9: oe_o follows dir_out_i. pin_o equals the latch when dir_out_i is 1 and is 0 otherwise.
- R10: Mode codes outside 4'b10xx take no match action: the latch and the flag do not change.
- R11: timer_clr_o and conv_start_o stay 0 for matches in every mode other than 4'b1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Match action select |
| cmp_val_i | input | 16 | Compare value |
| timer_i | input | 16 | Timer count |
| conv_en_i | input | 1 | Converter enabled, qualifies conv_start_o |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| dir_out_i | input | 1 | Pin direction, 1 = output |
| pin_o | output | 1 | Pin value |
| oe_o | output | 1 | Pin output enable |
| timer_clr_o | output | 1 | One-cycle timer reset pulse |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| match_flag_o | output | 1 | Sticky match interrupt flag |

## Verification
The equality is seen combinationally and every result is registered once. The latch, the flag and both pulses therefore change at the first rising edge after the equal cycle. The bench drives inputs on the falling edge and reads results on the next falling edge. Pulses are checked at that point and checked again one falling edge later to confirm they lasted one cycle. pin_o and oe_o are combinational in dir_out_i and are read within the cycle in which dir_out_i is driven.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

    localparam int CMU_MODE_W = 4;

    localparam logic [CMU_MODE_W-1:0] MD_OFF  = 4'b0000;
    localparam logic [CMU_MODE_W-1:0] MD_SET  = 4'b1000;
    localparam logic [CMU_MODE_W-1:0] MD_CLR  = 4'b1001;
    localparam logic [CMU_MODE_W-1:0] MD_SWI  = 4'b1010;
    localparam logic [CMU_MODE_W-1:0] MD_TRIG = 4'b1011;

    typedef struct packed {
        logic hit;
        logic drive_hi;
        logic drive_lo;
        logic trig;
    } cmu_evt_t;

    // compare logic runs only for the 4'b10xx group
    function automatic logic mode_active(input logic [CMU_MODE_W-1:0] m);
        return m[3:2] == 2'b10;
    endfunction

    function automatic cmu_evt_t decode_evt(input logic [CMU_MODE_W-1:0] m,
                                            input logic hit);
        cmu_evt_t e;
        e.hit      = hit;
        e.drive_hi = hit && (m == MD_SET);
        e.drive_lo = hit && (m == MD_CLR);
        e.trig     = hit && (m == MD_TRIG);
        return e;
    endfunction

endpackage

// File: rtl/cmu_match_detect.sv
module cmu_match_detect #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [TW-1:0] cmp,
    input  logic [TW-1:0] tmr,
    output logic          hit
);
    logic eq_now;
    logic eq_prev_q;

    assign eq_now = active && (cmp == tmr);
    assign hit    = eq_now && !eq_prev_q;

    always_ff @(posedge clk) begin
        if (rst) eq_prev_q <= 1'b0;
        else     eq_prev_q <= eq_now;
    end

    // R7: a held equality gives only its first cycle as an event
    a_r7_single_hit: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);
endmodule

// File: rtl/cmu_pin_latch.sv
module cmu_pin_latch
    import cmu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mode_off,
    input  cmu_evt_t evt,
    output logic     latch_q
);
    always_ff @(posedge clk) begin
        if (rst)               latch_q <= 1'b0;
        else if (mode_off)     latch_q <= 1'b0;
        else if (evt.drive_hi) latch_q <= 1'b1;
        else if (evt.drive_lo) latch_q <= 1'b0;
    end

    a_r8_off_forces_low: assert property (@(posedge clk) disable iff (rst)
        mode_off |=> !latch_q);
    a_r2_set_high: assert property (@(posedge clk) disable iff (rst)
        evt.drive_hi |=> latch_q);
    a_r4_keep_latch: assert property (@(posedge clk) disable iff (rst)
        (evt.hit && !evt.drive_hi && !evt.drive_lo && !mode_off) |=> $stable(latch_q));
endmodule

// File: rtl/cmu_irq_flag.sv
module cmu_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    a_r5_set_on_hit: assert property (@(posedge clk) disable iff (rst)
        set |=> flag_q);
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
    import cmu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CMU_MODE_W-1:0] mode_i,
    input  logic [TW-1:0]         cmp_val_i,
    input  logic [TW-1:0]         timer_i,
    input  logic                  conv_en_i,
    input  logic                  flag_clr_i,
    input  logic                  dir_out_i,
    output logic                  pin_o,
    output logic                  oe_o,
    output logic                  timer_clr_o,
    output logic                  conv_start_o,
    output logic                  match_flag_o
);
    logic     hit;
    logic     latch_q;
    cmu_evt_t evt;

    cmu_match_detect #(.TW(TW)) u_det (
        .clk    (clk),
        .rst    (rst),
        .active (mode_active(mode_i)),
        .cmp    (cmp_val_i),
        .tmr    (timer_i),
        .hit    (hit)
    );

    assign evt = decode_evt(mode_i, hit);

    cmu_pin_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .mode_off (mode_i == MD_OFF),
        .evt      (evt),
        .latch_q  (latch_q)
    );

    cmu_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (evt.hit),
        .clr    (flag_clr_i),
        .flag_q (match_flag_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_clr_o  <= 1'b0;
            conv_start_o <= 1'b0;
        end else begin
            timer_clr_o  <= evt.trig;
            conv_start_o <= evt.trig && conv_en_i;
        end
    end

    assign oe_o  = dir_out_i;
    assign pin_o = dir_out_i && latch_q;

    a_r6_clr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        timer_clr_o |=> !timer_clr_o);
    a_r6_start_with_clr: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> timer_clr_o);
    a_r11_trig_only: assert property (@(posedge clk) disable iff (rst)
        timer_clr_o |-> $past(mode_i) == MD_TRIG);
    a_r9_pin_gated: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> !pin_o);
endmodule

// File: tb/tb_cmp_match_unit.sv
module tb_cmp_match_unit;
    import cmu_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  mode_i;
    logic [15:0] cmp_val_i, timer_i;
    logic        conv_en_i, flag_clr_i, dir_out_i;
    logic        pin_o, oe_o, timer_clr_o, conv_start_o, match_flag_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cmp_match_unit dut (.*);

    // {mode, pre_latch, cmp, tmr, conv_en, exp_latch, exp_flag, exp_clr, exp_start}
    localparam int NV = 12;
    localparam logic [41:0] VEC [NV] = '{
        {4'b1000, 1'b0, 16'h1234, 16'h1234, 1'b0, 4'b1100},
        {4'b1000, 1'b0, 16'h1234, 16'h1235, 1'b0, 4'b0000},
        {4'b1001, 1'b1, 16'h00A5, 16'h00A5, 1'b0, 4'b0100},
        {4'b1001, 1'b1, 16'h00A5, 16'h00A4, 1'b0, 4'b1000},
        {4'b1010, 1'b1, 16'h7777, 16'h7777, 1'b0, 4'b1100},
        {4'b1010, 1'b0, 16'h7777, 16'h7777, 1'b1, 4'b0100},
        {4'b1011, 1'b0, 16'h0400, 16'h0400, 1'b1, 4'b0111},
        {4'b1011, 1'b1, 16'h0400, 16'h0400, 1'b0, 4'b1110},
        {4'b0100, 1'b0, 16'h0055, 16'h0055, 1'b1, 4'b0000},
        {4'b1100, 1'b1, 16'h0055, 16'h0055, 1'b1, 4'b1000},
        {4'b1000, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 4'b1100},
        {4'b1001, 1'b1, 16'h0000, 16'h0000, 1'b1, 4'b0100}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic preset(input logic [15:0] c, input logic pre);
        cmp_val_i = c; timer_i = ~c; mode_i = MD_OFF; flag_clr_i = 1'b1;
        cyc();
        flag_clr_i = 1'b0;
        if (pre) begin
            mode_i = MD_SET; timer_i = c; cyc();
            timer_i = ~c; cyc();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_i = MD_OFF; cmp_val_i = 16'h0; timer_i = 16'h1;
        conv_en_i = 1'b0; flag_clr_i = 1'b0; dir_out_i = 1'b1;
        cyc(); cyc();
        // R1 while in reset
        chk("R1 pin", pin_o, 1'b0);
        chk("R1 flag", match_flag_o, 1'b0);
        chk("R1 clr", timer_clr_o, 1'b0);
        chk("R1 start", conv_start_o, 1'b0);
        rst = 1'b0;
        cyc();
        chk("R1 pin after release", pin_o, 1'b0);

        // vector table: R2 R3 R4 R5 R6 R10 R11
        for (int i = 0; i < NV; i++) begin
            logic [3:0] vm; logic vpre; logic [15:0] vc, vt; logic ve; logic [3:0] ex;
            {vm, vpre, vc, vt, ve, ex} = VEC[i];
            preset(vc, vpre);
            mode_i = vm; conv_en_i = ve; flag_clr_i = 1'b1; timer_i = ~vc;
            cyc();
            flag_clr_i = 1'b0; timer_i = vt;
            cyc();
            chk($sformatf("R2/R3/R4/R10 latch v%0d", i), pin_o, ex[3]);
            chk($sformatf("R5 flag v%0d", i), match_flag_o, ex[2]);
            chk($sformatf("R6/R11 clr v%0d", i), timer_clr_o, ex[1]);
            chk($sformatf("R6 start v%0d", i), conv_start_o, ex[0]);
            timer_i = ~vc;
            cyc();
            chk($sformatf("R6 clr width v%0d", i), timer_clr_o, 1'b0);
            chk($sformatf("R5 sticky v%0d", i), match_flag_o, ex[2]);
        end

        // R7: equality held three cycles -> one trigger pulse
        preset(16'h0300, 1'b0);
        mode_i = MD_TRIG; conv_en_i = 1'b1; cyc();
        timer_i = 16'h0300; cyc();
        chk("R7 first pulse", timer_clr_o, 1'b1);
        cyc();
        chk("R7 no second pulse", timer_clr_o, 1'b0);
        cyc();
        chk("R7 no third pulse", conv_start_o, 1'b0);

        // R5: clear works, then set wins over simultaneous clear
        timer_i = 16'h0301; flag_clr_i = 1'b1; cyc();
        flag_clr_i = 1'b0;
        chk("R5 cleared", match_flag_o, 1'b0);
        mode_i = MD_SWI; timer_i = 16'h0300; flag_clr_i = 1'b1; cyc();
        flag_clr_i = 1'b0; timer_i = 16'h0301;
        chk("R5 set wins", match_flag_o, 1'b1);

        // R8: latch high, then mode zero forces it low at next edge
        preset(16'h0042, 1'b1);
        chk("R8 latch preset", pin_o, 1'b1);
        mode_i = MD_OFF; cyc();
        chk("R8 off forces low", pin_o, 1'b0);

        // R9: pin gated by direction, oe follows direction
        preset(16'h0042, 1'b1);
        dir_out_i = 1'b0; #1;
        chk("R9 pin gated", pin_o, 1'b0);
        chk("R9 oe low", oe_o, 1'b0);
        dir_out_i = 1'b1; #1;
        chk("R9 pin driven", pin_o, 1'b1);
        chk("R9 oe high", oe_o, 1'b1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule